// File: doc/BRIEF.md
# Synchronous FIFO with Selectable Show-Ahead Read

This block is a single-clock first-in first-out buffer for a chip's data paths. Words enter through a write request with its data and leave through a read request. The block reports full, empty and a used-words count. Data width, depth and the count width are parameters. Depth must equal two raised to the count width. When the buffer holds all of its words, the count rolls over to zero and only the full flag tells that state apart from empty.

A compile-time read mode picks one of two read behaviours:

- **Normal mode.** The read request pulls a word into an output register, so the word appears one clock after the request.
- **Show-ahead mode.** The oldest stored word is always presented on the read data output while the buffer is not empty. A read request then acknowledges that word and moves the output on to the next one.

Two further switches turn the write-side full guard and the read-side empty guard on or off. With a guard off, the matching request is never blocked, and the stored contents are undefined until the next clear.

Top module: `sync_fifo_sa`

## Requirements
- R1: DEPTH is at least 4 and equals 2**USED_W; the used-words output is USED_W bits wide.
- R2: While the buffer holds between 0 and DEPTH-1 words, used_o equals the number of stored words.
- R3: With exactly DEPTH words stored, full_o is 1, empty_o is 0 and used_o reads 0.
- R4: In normal mode an accepted read places the oldest word on rd_data_o right after the clock edge that accepts it, and words leave in write order.
- R5: In normal mode rd_data_o keeps its value on any cycle without an accepted read, including a read that is refused while empty.
- R6: In show-ahead mode, whenever empty_o is 0, rd_data_o shows the oldest stored word without any read request.
- R7: In show-ahead mode an accepted read removes the shown word, and after the edge rd_data_o shows the next word if one remains.
- R8: With the overflow guard on, a write request while full_o is 1 is dropped: count, flags and contents are unchanged.
- R9: With the underflow guard on, a read request while empty_o is 1 is dropped: count and flags are unchanged.
- R10: With a guard off, the request is accepted anyway. A write at DEPTH words gives full_o 0 and used_o 1; a read at zero words gives empty_o 0 and used_o DEPTH-1. Data is undefined until a clear.
- R11: A read and a write in the same cycle, with the buffer neither empty nor full, leave used_o unchanged and keep the order of the words.
- R12: clear_i (synchronous) and rst_ni low (asynchronous) both empty the buffer: empty_o 1, full_o 0, used_o 0. clear_i takes priority over requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear, active high |
| wr_req_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Data to store |
| rd_req_i | input | 1 | Read request (normal) or read acknowledge (show-ahead) |
| rd_data_o | output | DATA_W | Read data |
| full_o | output | 1 | Buffer holds DEPTH words |
| empty_o | output | 1 | Buffer holds no words |
| used_o | output | USED_W | Fill level, modulo DEPTH |

## Verification
The assertions check, on every cycle, these properties:

- Clearing gives the empty state.
- Guarded writes at full and guarded reads at empty change nothing.
- A balanced read and write keeps the count.
- The normal-mode output register holds whenever no read is accepted.

Only the bench scenarios can show the rest:

- Words come out in write order with the right latency in each mode.
- The count rolls over at full.
- A disabled guard really lets the corrupting access through.

// File: rtl/fifo_sa_pkg.sv
package fifo_sa_pkg;
  typedef enum logic {
    RD_NORMAL    = 1'b0,
    RD_SHOWAHEAD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_sa_ctrl.sv
module fifo_sa_ctrl #(
  parameter int unsigned USED_W    = 3,
  parameter bit          OVF_GUARD = 1'b1,
  parameter bit          UNF_GUARD = 1'b1,
  localparam int unsigned PTR_W    = USED_W + 1,
  localparam int unsigned DEPTH    = 1 << USED_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  output logic              wr_fire_o,
  output logic              rd_fire_o,
  output logic [USED_W-1:0] wr_addr_o,
  output logic [USED_W-1:0] rd_addr_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [USED_W-1:0] used_o
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, fill;

  // pointers carry one extra bit so DEPTH words differ from zero words
  assign fill    = wr_ptr_q - rd_ptr_q;
  assign full_o  = (fill == PTR_W'(DEPTH));
  assign empty_o = (fill == '0);
  assign used_o  = fill[USED_W-1:0];

  assign wr_fire_o = wr_req_i && !(OVF_GUARD && full_o) && !clear_i;
  assign rd_fire_o = rd_req_i && !(UNF_GUARD && empty_o) && !clear_i;
  assign wr_addr_o = wr_ptr_q[USED_W-1:0];
  assign rd_addr_o = rd_ptr_q[USED_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_fire_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_fire_o) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (empty_o && !full_o && used_o == '0));

  assert_rw_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_o && !empty_o && wr_req_i && rd_req_i && !clear_i) |=> $stable(used_o));

  if (OVF_GUARD) begin : g_ovf_chk
    assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && wr_req_i && !rd_req_i && !clear_i) |=> (full_o && $stable(wr_addr_o)));
  end
  if (UNF_GUARD) begin : g_unf_chk
    assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o && rd_req_i && !wr_req_i && !clear_i) |=> (empty_o && $stable(rd_addr_o)));
  end
endmodule

// File: rtl/fifo_sa_mem.sv
module fifo_sa_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] store_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) store_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = store_q[rd_addr_i];
endmodule

// File: rtl/fifo_sa_rdreg.sv
module fifo_sa_rdreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fire_i,
  input  logic [DATA_W-1:0] head_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_data_o <= '0;
    else if (rd_fire_i) rd_data_o <= head_i;
  end

  assert_rd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire_i |=> $stable(rd_data_o));
endmodule

// File: rtl/sync_fifo_sa.sv
module sync_fifo_sa
  import fifo_sa_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned USED_W    = 3,
  parameter rd_mode_e    RD_MODE   = RD_NORMAL,
  parameter bit          OVF_GUARD = 1'b1,
  parameter bit          UNF_GUARD = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [USED_W-1:0] used_o
);
  logic              wr_fire, rd_fire;
  logic [USED_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] head;

  initial begin
    assert_depth_R1: assert (DEPTH >= 4 && DEPTH == (1 << USED_W))
      else $error("sync_fifo_sa: DEPTH must be >= 4 and equal 2**USED_W");
  end

  fifo_sa_ctrl #(
    .USED_W(USED_W), .OVF_GUARD(OVF_GUARD), .UNF_GUARD(UNF_GUARD)
  ) u_ctrl (
    .clk_i, .rst_ni, .clear_i, .wr_req_i, .rd_req_i,
    .wr_fire_o(wr_fire), .rd_fire_o(rd_fire),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .full_o, .empty_o, .used_o
  );

  fifo_sa_mem #(.DATA_W(DATA_W), .ADDR_W(USED_W)) u_mem (
    .clk_i, .wr_en_i(wr_fire), .wr_addr_i(wr_addr), .wr_data_i,
    .rd_addr_i(rd_addr), .rd_data_o(head)
  );

  if (RD_MODE == RD_SHOWAHEAD) begin : g_showahead
    // oldest word drives the output directly; a read only advances the pointer
    assign rd_data_o = head;
  end else begin : g_normal
    fifo_sa_rdreg #(.DATA_W(DATA_W)) u_rdreg (
      .clk_i, .rst_ni, .rd_fire_i(rd_fire), .head_i(head), .rd_data_o
    );
  end
endmodule

// File: tb/sync_fifo_sa_tb.sv
module sync_fifo_sa_tb;
  import fifo_sa_pkg::*;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int UW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wd = '0;

  logic [DW-1:0] n_rd, s_rd, g_rd;
  logic n_full, n_empty, s_full, s_empty, g_full, g_empty;
  logic [UW-1:0] n_used, s_used, g_used;

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_rd = '0;

  always #2 clk = ~clk;

  sync_fifo_sa #(.DATA_W(DW), .DEPTH(DEPTH), .USED_W(UW), .RD_MODE(RD_NORMAL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .wr_req_i(wr), .wr_data_i(wd),
    .rd_req_i(rd), .rd_data_o(n_rd), .full_o(n_full), .empty_o(n_empty), .used_o(n_used));

  sync_fifo_sa #(.DATA_W(DW), .DEPTH(DEPTH), .USED_W(UW), .RD_MODE(RD_SHOWAHEAD)) u_dut_sa (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .wr_req_i(wr), .wr_data_i(wd),
    .rd_req_i(rd), .rd_data_o(s_rd), .full_o(s_full), .empty_o(s_empty), .used_o(s_used));

  sync_fifo_sa #(.DATA_W(DW), .DEPTH(DEPTH), .USED_W(UW), .RD_MODE(RD_NORMAL),
                 .OVF_GUARD(1'b0), .UNF_GUARD(1'b0)) u_dut_ng (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .wr_req_i(wr), .wr_data_i(wd),
    .rd_req_i(rd), .rd_data_o(g_rd), .full_o(g_full), .empty_o(g_empty), .used_o(g_used));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, sample 1 ns after the rising edge
  task automatic step(input logic c, input logic w, input logic [DW-1:0] d, input logic r);
    bit wf, rf;
    @(negedge clk);
    clr = c; wr = w; wd = d; rd = r;
    wf = w && !c && (q.size() != DEPTH);
    rf = r && !c && (q.size() != 0);
    @(posedge clk);
    #1;
    clr = 1'b0; wr = 1'b0; rd = 1'b0;
    if (c) q.delete();
    else begin
      if (rf) exp_rd = q.pop_front();
      if (wf) q.push_back(d);
    end
  endtask

  task automatic t_reset();
    check("R12 empty after reset", n_empty, 1);
    check("R12 full after reset", n_full, 0);
    check("R12 used after reset", n_used, 0);
    check("R12 rd_data after reset", n_rd, 0);
    check("R1 used width", $bits(n_used), UW);
    check("R1 depth vs width", DEPTH, 1 << UW);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 1, DW'(8'h10 + i), 0);
      if (i < DEPTH - 1) begin
        check("R2 used while filling", n_used, i + 1);
        check("R2 full low while filling", n_full, 0);
      end
      if (i == 0) check("R6 show-ahead head after first write", s_rd, 8'h10);
    end
    check("R3 full at depth", n_full, 1);
    check("R3 used wraps to zero", n_used, 0);
    check("R3 empty low at depth", n_empty, 0);
  endtask

  task automatic t_overflow();
    step(0, 1, 8'hEE, 0);
    check("R8 full stays after refused write", n_full, 1);
    check("R8 used unchanged", n_used, 0);
    check("R8 show-ahead head unchanged", s_rd, 8'h10);
    check("R10 unguarded write leaves full", g_full, 0);
    check("R10 unguarded used after overflow", g_used, 1);
  endtask

  task automatic t_drain();
    for (int i = 0; i < DEPTH; i++) begin
      check("R6 head shown without request", s_rd, q[0]);
      step(0, 0, '0, 1);
      check("R4 normal read data in order", n_rd, exp_rd);
      check("R2 used while draining", n_used, DEPTH - 1 - i);
      if (q.size() != 0) check("R7 show-ahead advances", s_rd, q[0]);
    end
    check("R4 empty after drain", n_empty, 1);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] last;
    last = n_rd;
    step(0, 0, '0, 1);
    check("R9 empty stays on refused read", n_empty, 1);
    check("R9 used unchanged", n_used, 0);
    check("R5 rd_data holds on refused read", n_rd, last);
    step(1, 0, '0, 0);
    check("R12 unguarded instance cleared", g_empty, 1);
    step(0, 0, '0, 1);
    check("R10 unguarded read leaves empty", g_empty, 0);
    check("R10 unguarded used after underflow", g_used, DEPTH - 1);
    check("R9 guarded still empty", n_empty, 1);
    step(1, 0, '0, 0);
    check("R12 clear restores unguarded", g_used, 0);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) step(0, 1, DW'(8'h40 + i), 0);
    for (int i = 0; i < 4; i++) begin
      check("R6 head before simultaneous access", s_rd, q[0]);
      step(0, 1, DW'(8'h50 + i), 1);
      check("R11 used unchanged", n_used, 3);
      check("R11 normal data order", n_rd, exp_rd);
      check("R7 show-ahead next word", s_rd, q[0]);
    end
  endtask

  task automatic t_hold();
    logic [DW-1:0] last;
    last = n_rd;
    for (int i = 0; i < 3; i++) begin
      step(0, 0, '0, 0);
      check("R5 rd_data holds when idle", n_rd, last);
    end
  endtask

  task automatic t_clear();
    step(1, 1, 8'hAA, 1);
    check("R12 empty after clear", n_empty, 1);
    check("R12 full low after clear", n_full, 0);
    check("R12 used zero after clear", n_used, 0);
    check("R12 show-ahead empty after clear", s_empty, 1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_fill();
    t_overflow();
    t_drain();
    t_underflow();
    t_simul();
    t_hold();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule